// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block performs the arithmetic and logical step of a 32-bit RISC data-processing instruction. Operand A comes from the first source register. Operand M is the second operand, which has already been shifted or rotated upstream. A 4-bit opcode selects one of sixteen operations. The result is produced combinationally, together with a write-enable that tells the register file whether the destination register should take the result.

The block also holds the four condition flags: negative, zero, carry and overflow. It updates them on the clock edge when the instruction requests a flag update and the destination is not the program counter. Addition-family and subtraction-family operations compute carry and overflow. Logical operations clear carry and keep overflow.

Subtract-with-carry and reverse-subtract-with-carry both use the convention "+ C - 1", so the carry flag means "no borrow". Four opcodes (bitwise test, equivalence test, compare and compare-negative) only set the flags and never write a register. The carry-in comes from the caller's current carry flag.

Top module: `dp_alu_core`

## Requirements
- R1: Opcode 0000 gives A & M, 0001 gives A ^ M, 1100 gives A | M, 1101 gives M, 1110 gives A & ~M, and 1111 gives ~M.
- R2: Opcode 0100 gives A + M, and opcode 0101 gives A + M + carry_i, both modulo 2^32.
- R3: Opcode 0010 gives A - M, and opcode 0011 gives M - A, both modulo 2^32.
- R4: Opcode 0110 gives A - M + carry_i - 1, and opcode 0111 gives M - A + carry_i - 1, both modulo 2^32.
- R5: `res_we_o` is 0 for opcodes 1000, 1001, 1010 and 1011, and 1 for every other opcode. Opcodes 1000 and 1001 evaluate A & M and A ^ M, 1010 evaluates A - M, and 1011 evaluates A + M; these values affect only the flags.
- R6: The flags are loaded at a rising clock edge only if `set_flags_i` is 1 and `dest_i` is not 15. Otherwise all four flags keep their values.
- R7: For opcodes 0100, 0101 and 1011, C is the carry out of bit 31. V is 1 when A and M have the same sign and the result's sign differs from it.
- R8: For opcodes 0010, 0011, 0110, 0111 and 1010, call the minuend X and the subtrahend Y (these are swapped for 0011 and 0111). C is 1 exactly when no borrow occurs, that is when X >= Y + (1 - cin), where cin is 1 for 0010, 0011 and 1010 and carry_i otherwise. V is 1 when X and Y differ in sign and the result's sign differs from X.
- R9: For every flag-loading operation, N is result bit 31 and Z is 1 when the result is zero. For logical opcodes (0000, 0001, 1000, 1001, 1100 to 1111), C is loaded with 0 and V keeps its previous value.
- R10: While `rst_n` is low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| m_i | input | 32 | Second operand (already shifted or immediate) |
| carry_i | input | 1 | Current carry flag, used by the carry-consuming opcodes |
| set_flags_i | input | 1 | Request to update the flags |
| dest_i | input | 4 | Destination register index |
| res_o | output | 32 | Operation result |
| res_we_o | output | 1 | Result write-back enable |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry / no-borrow flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
The clocked checks assume two things about the inputs. First, the opcode, operands and control bits are valid and stable around each rising edge. Second, `carry_i` is a known value. The adder check skips any cycle with unknown operands.

The stimulus follows these assumptions. It changes every input just after a falling edge, and it drives each input to a defined value from reset onward. It covers all sixteen opcodes on sign-boundary and wrap-around operands, with both carry-in values. It also covers the three flag-gating cases: the flag request off, the destination equal to 15, and the destination equal to 14.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'b0000,
      OP_EOR = 4'b0001,
      OP_SUB = 4'b0010,
      OP_RSB = 4'b0011,
      OP_ADD = 4'b0100,
      OP_ADC = 4'b0101,
      OP_SBC = 4'b0110,
      OP_RSC = 4'b0111,
      OP_TST = 4'b1000,
      OP_TEQ = 4'b1001,
      OP_CMP = 4'b1010,
      OP_CMN = 4'b1011,
      OP_ORR = 4'b1100,
      OP_MOV = 4'b1101,
      OP_BIC = 4'b1110,
      OP_MVN = 4'b1111
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } alu_flags_t;

   // Flag-only opcodes: the result is never written back.
   function automatic logic op_flags_only(input logic [3:0] op);
      return op[3:2] == 2'b10;
   endfunction

   // Opcodes that go through the adder.
   function automatic logic op_is_arith(input logic [3:0] op);
      return (op[3:2] == 2'b01) || (op[3:1] == 3'b001) || (op[3:1] == 3'b101);
   endfunction

   // Opcodes that subtract (M is inverted, or A for the reversed forms).
   function automatic logic op_is_sub(input logic [3:0] op);
      return (op == OP_SUB) || (op == OP_RSB) || (op == OP_SBC) ||
             (op == OP_RSC) || (op == OP_CMP);
   endfunction

   // Reversed subtraction: M is the minuend.
   function automatic logic op_is_rev(input logic [3:0] op);
      return (op == OP_RSB) || (op == OP_RSC);
   endfunction

   // Opcodes that take the incoming carry.
   function automatic logic op_uses_carry(input logic [3:0] op);
      return (op == OP_ADC) || (op == OP_SBC) || (op == OP_RSC);
   endfunction

endpackage

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] m_i,
   output logic [DATA_W-1:0] res_o
);

   if (DATA_W < 2) begin : g_bad_width
      $error("dp_alu_logic: DATA_W must be at least 2");
   end

   always_comb begin
      unique case (alu_op_e'(op_i))
         OP_AND, OP_TST: res_o = a_i & m_i;
         OP_EOR, OP_TEQ: res_o = a_i ^ m_i;
         OP_ORR:         res_o = a_i | m_i;
         OP_MOV:         res_o = m_i;
         OP_BIC:         res_o = a_i & ~m_i;
         OP_MVN:         res_o = ~m_i;
         default:        res_o = '0;
      endcase
   end

endmodule

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
   import dp_alu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter bit RIPPLE_FORM = 1'b0
) (
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] m_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cout_o,
   output logic              ovf_o
);

   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("dp_alu_arith: DATA_W must be at least 2");
   end

   logic              sub_sel;
   logic              rev_sel;
   logic              cin;
   logic [DATA_W-1:0] minuend;
   logic [DATA_W-1:0] addend;
   logic [DATA_W-1:0] sum;
   logic              carry_out;

   always_comb begin
      sub_sel = op_is_sub(op_i);
      rev_sel = op_is_rev(op_i);
      minuend = rev_sel ? m_i : a_i;
      if (sub_sel) addend = rev_sel ? ~a_i : ~m_i;
      else         addend = m_i;
      if (op_uses_carry(op_i)) cin = carry_i;
      else                     cin = sub_sel;
   end

   if (RIPPLE_FORM) begin : g_ripple
      logic [DATA_W:0] chain;
      assign chain[0] = cin;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign sum[i]     = minuend[i] ^ addend[i] ^ chain[i];
         assign chain[i+1] = (minuend[i] & addend[i]) |
                             (chain[i] & (minuend[i] ^ addend[i]));
      end
      assign carry_out = chain[DATA_W];
   end else begin : g_flat
      logic [DATA_W:0] wide;
      assign wide      = {1'b0, minuend} + {1'b0, addend} + {{DATA_W{1'b0}}, cin};
      assign sum       = wide[DATA_W-1:0];
      assign carry_out = wide[DATA_W];
   end

   assign res_o  = sum;
   assign cout_o = carry_out;
   assign ovf_o  = (minuend[MSB] == addend[MSB]) && (sum[MSB] != minuend[MSB]);

   // R7 R8: with a carry out the sum wraps to at most the first operand
   always_comb begin
      if (!$isunknown({minuend, addend, cin})) begin
         adder_wrap_chk: assert (carry_out ? (sum <= minuend) : (sum >= minuend))
            else $error("adder carry disagrees with wrap of the sum");
      end
   end

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
   import dp_alu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit ZERO_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_i,
   input  logic              arith_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic              cout_i,
   input  logic              ovf_i,
   output alu_flags_t        flags_o
);

   localparam int MSB = DATA_W - 1;

   logic       is_zero;
   alu_flags_t flags_q;
   alu_flags_t flags_d;

   if (ZERO_TREE) begin : g_zero_fold
      logic [DATA_W:0] any_set;
      assign any_set[0] = 1'b0;
      for (genvar i = 0; i < DATA_W; i++) begin : g_or
         assign any_set[i+1] = any_set[i] | res_i[i];
      end
      assign is_zero = ~any_set[DATA_W];
   end else begin : g_zero_flat
      assign is_zero = ~|res_i;
   end

   always_comb begin
      flags_d.n = res_i[MSB];
      flags_d.z = is_zero;
      flags_d.c = arith_i ? cout_i : 1'b0;
      flags_d.v = arith_i ? ovf_i  : flags_q.v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flags_q <= '0;
      else if (upd_i) flags_q <= flags_d;
   end

   assign flags_o = flags_q;

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R6
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !upd_i) |=> $stable(flags_q))
      else $error("flags moved without an update");

   // R9
   logic_clear_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !arith_i) |=> !flags_q.c)
      else $error("logical op left carry set");

   // R9
   logic_keep_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && upd_i && !arith_i) |=> $stable(flags_q.v))
      else $error("logical op changed overflow");

   // R10
   reset_zero_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (flags_q == '0))
      else $error("flags not cleared by reset");

endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
   import dp_alu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int IDX_W       = 4,
   parameter int PC_IDX      = 15,
   parameter bit RIPPLE_FORM = 1'b0,
   parameter bit ZERO_TREE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] m_i,
   input  logic              carry_i,
   input  logic              set_flags_i,
   input  logic [IDX_W-1:0]  dest_i,
   output logic [DATA_W-1:0] res_o,
   output logic              res_we_o,
   output logic              flag_n_o,
   output logic              flag_z_o,
   output logic              flag_c_o,
   output logic              flag_v_o
);

   localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

   if (PC_IDX < 0 || PC_IDX >= (1 << IDX_W)) begin : g_bad_pc
      $error("dp_alu_core: PC_IDX does not fit in IDX_W bits");
   end

   logic [DATA_W-1:0] logic_res;
   logic [DATA_W-1:0] arith_res;
   logic              arith_cout;
   logic              arith_ovf;
   logic              arith_sel;
   logic              flag_upd;
   alu_flags_t        flags;

   dp_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .op_i  (op_i),
      .a_i   (a_i),
      .m_i   (m_i),
      .res_o (logic_res)
   );

   dp_alu_arith #(.DATA_W(DATA_W), .RIPPLE_FORM(RIPPLE_FORM)) u_arith (
      .op_i    (op_i),
      .a_i     (a_i),
      .m_i     (m_i),
      .carry_i (carry_i),
      .res_o   (arith_res),
      .cout_o  (arith_cout),
      .ovf_o   (arith_ovf)
   );

   assign arith_sel = op_is_arith(op_i);
   assign res_o     = arith_sel ? arith_res : logic_res;
   assign res_we_o  = ~op_flags_only(op_i);
   assign flag_upd  = set_flags_i && (dest_i != PC_SEL);

   dp_alu_flags #(.DATA_W(DATA_W), .ZERO_TREE(ZERO_TREE)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_i   (flag_upd),
      .arith_i (arith_sel),
      .res_i   (res_o),
      .cout_i  (arith_cout),
      .ovf_i   (arith_ovf),
      .flags_o (flags)
   );

   assign flag_n_o = flags.n;
   assign flag_z_o = flags.z;
   assign flag_c_o = flags.c;
   assign flag_v_o = flags.v;

   // R6
   pc_dest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dest_i == PC_SEL) |=> $stable({flag_n_o, flag_z_o, flag_c_o, flag_v_o}))
      else $error("flags changed for a program-counter destination");

   // R9
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_upd |=> (flag_z_o == ($past(res_o) == '0)))
      else $error("zero flag disagrees with loaded result");

   // R1
   move_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_MOV) |-> (res_o == m_i))
      else $error("move does not pass the second operand");

endmodule

// File: tb/dp_alu_core_tb.sv
module dp_alu_core_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_i = '0;
   logic [31:0] a_i = '0;
   logic [31:0] m_i = '0;
   logic        carry_i = 1'b0;
   logic        set_flags_i = 1'b0;
   logic [3:0]  dest_i = '0;
   logic [31:0] res_o;
   logic        res_we_o;
   logic        flag_n_o, flag_z_o, flag_c_o, flag_v_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic en, ez, ec, ev;   // modelled flags

   always #(CLK_PERIOD/2) clk = ~clk;

   dp_alu_core u_dut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .m_i(m_i),
      .carry_i(carry_i), .set_flags_i(set_flags_i), .dest_i(dest_i),
      .res_o(res_o), .res_we_o(res_we_o),
      .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
      .flag_c_o(flag_c_o), .flag_v_o(flag_v_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Reference built from the requirement text with 33-bit arithmetic.
   task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] m,
                        input logic c, output logic [31:0] r, output logic cf,
                        output logic vf, output logic arith, output string rt,
                        output string ft);
      logic [32:0] t;
      logic [31:0] x, y;
      logic bin;
      arith = 1'b0; cf = 1'b0; vf = 1'b0; r = '0; rt = "R1"; ft = "R9";
      case (op)
         4'h0, 4'h8: r = a & m;
         4'h1, 4'h9: r = a ^ m;
         4'hC: r = a | m;
         4'hD: r = m;
         4'hE: r = a & ~m;
         4'hF: r = ~m;
         4'h4, 4'h5, 4'hB: begin
            t = {1'b0, a} + {1'b0, m} + ((op == 4'h5) ? 33'd1 * c : 33'd0);
            r = t[31:0]; cf = t[32]; arith = 1'b1;
            vf = (a[31] == m[31]) && (r[31] != a[31]);
            rt = "R2"; ft = "R7";
         end
         default: begin
            x = (op == 4'h3 || op == 4'h7) ? m : a;
            y = (op == 4'h3 || op == 4'h7) ? a : m;
            bin = (op == 4'h6 || op == 4'h7) ? !c : 1'b0;
            t = {1'b0, x} - {1'b0, y} - {32'd0, bin};
            r = t[31:0]; cf = !t[32]; arith = 1'b1;
            vf = (x[31] != y[31]) && (r[31] != x[31]);
            rt = (op == 4'h6 || op == 4'h7) ? "R4" : "R3";
            ft = "R8";
         end
      endcase
   endtask

   task automatic run_vec(input logic [3:0] op, input logic [31:0] a, input logic [31:0] m,
                          input logic c, input logic s, input logic [3:0] dst);
      logic [31:0] r;
      logic cf, vf, ar, upd;
      string rt, ft;
      model(op, a, m, c, r, cf, vf, ar, rt, ft);
      op_i = op; a_i = a; m_i = m; carry_i = c; set_flags_i = s; dest_i = dst;
      #1;
      if (op[3:2] != 2'b10) check({rt, " result"}, res_o, r);
      check("R5 write enable", {31'd0, res_we_o}, {31'd0, op[3:2] != 2'b10});
      upd = s && (dst != 4'd15);
      @(posedge clk); #1;
      if (upd) begin
         en = r[31]; ez = (r == 0); ec = cf;
         if (ar) ev = vf;
      end
      if (!upd) ft = "R6";
      check({ft, " N"}, {31'd0, flag_n_o}, {31'd0, en});
      check({ft, " Z"}, {31'd0, flag_z_o}, {31'd0, ez});
      check({ft, " C"}, {31'd0, flag_c_o}, {31'd0, ec});
      check({ft, " V"}, {31'd0, flag_v_o}, {31'd0, ev});
      @(negedge clk);
   endtask

   task automatic t_reset;
      check("R10 N", {31'd0, flag_n_o}, 32'd0);
      check("R10 Z", {31'd0, flag_z_o}, 32'd0);
      check("R10 C", {31'd0, flag_c_o}, 32'd0);
      check("R10 V", {31'd0, flag_v_o}, 32'd0);
   endtask

   task automatic t_all_ops;
      logic [31:0] av [6] = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'h1234_5678, 32'h0000_0005};
      logic [31:0] mv [6] = '{32'h0, 32'h0000_0001, 32'h0000_0001, 32'h8000_0000,
                              32'h0F0F_F0F0, 32'h0000_0005};
      for (int op = 0; op < 16; op++)
         for (int k = 0; k < 6; k++)
            for (int c = 0; c < 2; c++)
               run_vec(4'(op), av[k], mv[k], 1'(c), 1'b1, 4'd0);
   endtask

   task automatic t_carry_edges;
      run_vec(4'h5, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1, 4'd1);   // R2 R7 wrap to zero
      run_vec(4'h5, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1, 4'd1);
      run_vec(4'h6, 32'd5, 32'd5, 1'b0, 1'b1, 4'd2);            // R4 R8 borrow
      run_vec(4'h6, 32'd5, 32'd5, 1'b1, 1'b1, 4'd2);
      run_vec(4'h7, 32'd3, 32'd9, 1'b0, 1'b1, 4'd3);            // R4 reversed
      run_vec(4'h7, 32'd9, 32'd3, 1'b1, 1'b1, 4'd3);
      run_vec(4'h3, 32'd1, 32'h8000_0000, 1'b0, 1'b1, 4'd4);    // R3 R8 overflow
   endtask

   task automatic t_flag_gate;
      run_vec(4'h2, 32'd1, 32'd2, 1'b0, 1'b1, 4'd5);      // sets N
      run_vec(4'h4, 32'd0, 32'd0, 1'b0, 1'b0, 4'd5);      // R6 S clear
      run_vec(4'hD, 32'd0, 32'd0, 1'b0, 1'b1, 4'd15);     // R6 PC dest
      run_vec(4'hD, 32'd0, 32'd0, 1'b0, 1'b1, 4'd14);     // loads
      run_vec(4'hA, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'd15);
      run_vec(4'hA, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'd0); // sets V
      run_vec(4'h9, 32'hA, 32'hA, 1'b1, 1'b1, 4'd0);      // R9 V kept, C cleared
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      en = 0; ez = 0; ec = 0; ev = 0;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_all_ops;
      t_carry_edges;
      t_flag_gate;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule